// File: doc/BRIEF.md
# Legacy System I/O Register Block

This block is a byte-wide control and status register set that sits on an 8-bit I/O port bus and answers a handful of fixed port addresses. It holds the soft-reset request and the I/O map mode, each of which drives a sideband output directly. It also holds a masked system-control byte. It presents two strap bytes, one for installed equipment and one for the board identity, as read-only ports. It answers a keylock status port and accepts and discards writes to a group of sink ports. A request for little-endian operation is not supported. Such a request raises a sticky error flag, so that surrounding logic can halt the system.

All bit positions inside a register count from the most significant end: bit n has the mask value 1 << (7 - n). Writes take effect on the clock edge where the write strobe is high. Read data is combinational from the port address. Beside the port bus, the block owns a 4-byte memory-mapped window at a parameterised base address (default 0xBFFFEFF0). The window models a parity-error status location: only 32-bit reads are legal there, and every other access to it is flagged.

Top module: `sysio_regs`

## Requirements
- R1: A write to port 0x092 stores only data bit value 0x01. From the cycle after the write, soft_reset_o equals that stored bit. A read of 0x092 returns the stored byte (0x00 or 0x01).
- R2: A write to port 0x092 with data bit value 0x02 set raises le_error_o from the next cycle. The flag stays high until reset, even if later writes have that bit clear.
- R3: A write to port 0x81C stores the data ANDed with 0xF0, and a read of 0x81C returns that stored value.
- R4: A write to port 0x850 stores the data ANDed with 0x01. From the next cycle, map_noncontig_o equals the stored bit. A read of 0x850 returns the stored byte.
- R5: While reset is asserted and after it, ports 0x092 and 0x81C read 0x00 and port 0x850 reads 0x01. In the same state map_noncontig_o is 1, while soft_reset_o, le_error_o and mm_bad_o are 0.
- R6: Port 0x80C reads the equipment strap byte and port 0x852 reads the board strap byte. Both follow their strap pins, and writes to these ports change nothing.
- R7: Port 0x818 (keylock) always reads 0x00, and writes to it change nothing.
- R8: Writes to the sink ports 0x808, 0x810, 0x812 and 0x814 are accepted and leave every register and output unchanged. Reads of these ports return 0xFF.
- R9: Reads of any port address that is not decoded return 0xFF, and writes to such addresses change nothing.
- R10: A read with mm_size = 2 (32-bit; 0 is byte, 1 is 16-bit) at any address from the window base to base+3 raises mm_ack in the same cycle, with mm_rdata = 0. Accesses outside the window never raise mm_ack.
- R11: Within the window, any write and any read of a size other than 32-bit raise mm_bad_o for exactly the following cycle. Accesses outside the window never raise mm_bad_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | Port address |
| io_wr | input | 1 | Port write strobe |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Port read data (combinational from io_addr) |
| equip_strap | input | 8 | Equipment strap byte |
| board_strap | input | 8 | Board identity strap byte |
| soft_reset_o | output | 1 | Soft-reset request |
| map_noncontig_o | output | 1 | Non-contiguous I/O map select |
| le_error_o | output | 1 | Sticky unsupported-endianness error |
| mm_addr | input | 32 | Memory-mapped address |
| mm_rd | input | 1 | Memory read strobe |
| mm_wr | input | 1 | Memory write strobe |
| mm_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| mm_rdata | output | 32 | Window read data |
| mm_ack | output | 1 | Legal window read accepted |
| mm_bad_o | output | 1 | Illegal window access, one-cycle pulse |

## Verification
The port registers are written with all-ones, alternating-nibble and single-bit patterns. This shows whether each write mask keeps exactly the right bits, and in particular shows that MSB-0 numbering places the soft-reset and map bits at value 0x01. Writes to the sink, strap, keylock and undecoded ports are followed by reads of every stored register and a look at every output, which tells a truly ignored write apart from one that leaks into a neighbour. The window is accessed at both ends of its range, just outside each end, with each access size and in both directions. This separates the legal 32-bit read from flagged accesses and from accesses that are not in the window at all.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

   // MSB-0 numbering: bit n of a byte has value 1 << (7 - n)
   function automatic logic [7:0] msb0_bit(input int unsigned n);
      return 8'(8'd1 << (7 - n));
   endfunction

   localparam int PORT_SRESET  = 'h092;
   localparam int PORT_EQUIP   = 'h80C;
   localparam int PORT_KEYLOCK = 'h818;
   localparam int PORT_SYSCTL  = 'h81C;
   localparam int PORT_MAPMODE = 'h850;
   localparam int PORT_BOARD   = 'h852;

   localparam int NUM_SINK = 4;
   localparam int SINK_PORTS [NUM_SINK] = '{'h808, 'h810, 'h812, 'h814};

   localparam logic [7:0] SR_BIT   = msb0_bit(7);
   localparam logic [7:0] LE_BIT   = msb0_bit(6);
   localparam logic [7:0] SC_MASK  = msb0_bit(0) | msb0_bit(1) | msb0_bit(2) | msb0_bit(3);
   localparam logic [7:0] MAP_BIT  = msb0_bit(7);
   localparam logic [7:0] KEY_IDLE = 8'h00;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } mm_size_e;

   typedef struct packed {
      logic sreset;
      logic sysctl;
      logic mapmode;
      logic equip;
      logic board;
      logic keylock;
      logic sink;
   } port_sel_t;

endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
   import sysio_pkg::*;
#(
   parameter int IO_AW = 16
) (
   input  logic [IO_AW-1:0] addr,
   output port_sel_t        sel
);

   logic [NUM_SINK-1:0] sink_hit;

   for (genvar i = 0; i < NUM_SINK; i++) begin : g_sink
      assign sink_hit[i] = (addr == IO_AW'(SINK_PORTS[i]));
   end

   always_comb begin
      sel         = '0;
      sel.sreset  = (addr == IO_AW'(PORT_SRESET));
      sel.sysctl  = (addr == IO_AW'(PORT_SYSCTL));
      sel.mapmode = (addr == IO_AW'(PORT_MAPMODE));
      sel.equip   = (addr == IO_AW'(PORT_EQUIP));
      sel.board   = (addr == IO_AW'(PORT_BOARD));
      sel.keylock = (addr == IO_AW'(PORT_KEYLOCK));
      sel.sink    = |sink_hit;
   end

endmodule

// File: rtl/sysio_ctrl_regs.sv
module sysio_ctrl_regs
   import sysio_pkg::*;
#(
   parameter logic [7:0] MAP_RESET = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  port_sel_t  sel,
   output logic [7:0] sreset_q,
   output logic [7:0] sysctl_q,
   output logic [7:0] map_q,
   output logic       le_err_q
);

   localparam logic [7:0] MAP_RST_MASKED = MAP_RESET & MAP_BIT;

   logic le_req;
   assign le_req = (wdata & LE_BIT) != 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreset_q <= 8'h00;
         sysctl_q <= 8'h00;
         map_q    <= MAP_RST_MASKED;
         le_err_q <= 1'b0;
      end else if (wr) begin
         if (sel.sreset) begin
            sreset_q <= wdata & SR_BIT;
            if (le_req) begin
               le_err_q <= 1'b1;
            end
         end
         if (sel.sysctl) begin
            sysctl_q <= wdata & SC_MASK;
         end
         if (sel.mapmode) begin
            map_q <= wdata & MAP_BIT;
         end
      end
   end

endmodule

// File: rtl/sysio_rdmux.sv
module sysio_rdmux
   import sysio_pkg::*;
#(
   parameter logic [7:0] UNMAPPED = 8'hFF
) (
   input  port_sel_t  sel,
   input  logic [7:0] sreset_q,
   input  logic [7:0] sysctl_q,
   input  logic [7:0] map_q,
   input  logic [7:0] equip,
   input  logic [7:0] board,
   output logic [7:0] rdata
);

   always_comb begin
      rdata = UNMAPPED;
      if (sel.sreset) begin
         rdata = sreset_q;
      end else if (sel.sysctl) begin
         rdata = sysctl_q;
      end else if (sel.mapmode) begin
         rdata = map_q;
      end else if (sel.equip) begin
         rdata = equip;
      end else if (sel.board) begin
         rdata = board;
      end else if (sel.keylock) begin
         rdata = KEY_IDLE;
      end
   end

endmodule

// File: rtl/sysio_parity_win.sv
module sysio_parity_win
   import sysio_pkg::*;
#(
   parameter int          MM_AW  = 32,
   parameter int          MM_DW  = 32,
   parameter int          WIN_BYTES = 4,
   parameter logic [31:0] BASE   = 32'hBFFF_EFF0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MM_AW-1:0] addr,
   input  logic             rd,
   input  logic             wr,
   input  logic [1:0]       size,
   output logic [MM_DW-1:0] rdata,
   output logic             ack,
   output logic             bad_q
);

   localparam int OFS_W = $clog2(WIN_BYTES);
   localparam logic [MM_AW-1:0] BASE_A = MM_AW'(BASE);

   logic in_win;
   logic word_sz;

   assign in_win  = addr[MM_AW-1:OFS_W] == BASE_A[MM_AW-1:OFS_W];
   assign word_sz = (size == SZ_WORD);
   assign ack     = in_win & rd & word_sz;
   assign rdata   = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad_q <= 1'b0;
      end else begin
         bad_q <= in_win & (wr | (rd & ~word_sz));
      end
   end

endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
   import sysio_pkg::*;
#(
   parameter int          IO_AW          = 16,
   parameter int          MM_AW          = 32,
   parameter int          MM_DW          = 32,
   parameter int          WIN_BYTES      = 4,
   parameter logic [31:0] PARITY_BASE    = 32'hBFFF_EFF0,
   parameter logic [7:0]  MAP_RESET      = 8'h01,
   parameter logic [7:0]  UNMAPPED_READ  = 8'hFF,
   parameter bit          STRAPS_FROM_PINS = 1'b1,
   parameter logic [7:0]  EQUIP_FIXED    = 8'h00,
   parameter logic [7:0]  BOARD_FIXED    = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IO_AW-1:0] io_addr,
   input  logic             io_wr,
   input  logic [7:0]       io_wdata,
   output logic [7:0]       io_rdata,
   input  logic [7:0]       equip_strap,
   input  logic [7:0]       board_strap,
   output logic             soft_reset_o,
   output logic             map_noncontig_o,
   output logic             le_error_o,
   input  logic [MM_AW-1:0] mm_addr,
   input  logic             mm_rd,
   input  logic             mm_wr,
   input  logic [1:0]       mm_size,
   output logic [MM_DW-1:0] mm_rdata,
   output logic             mm_ack,
   output logic             mm_bad_o
);

   if (IO_AW < 12) begin : g_bad_aw
      $error("IO_AW must cover port 0x852");
   end
   if (MM_AW < 3 || MM_AW > 32) begin : g_bad_mmaw
      $error("MM_AW out of range");
   end
   if (WIN_BYTES < 2 || (WIN_BYTES & (WIN_BYTES - 1)) != 0) begin : g_bad_win
      $error("WIN_BYTES must be a power of two");
   end
   if ((PARITY_BASE % WIN_BYTES) != 0) begin : g_bad_base
      $error("PARITY_BASE must be window aligned");
   end

   port_sel_t  sel;
   logic [7:0] sreset_q, sysctl_q, map_q;
   logic       le_err_q;
   logic [7:0] equip_v, board_v;

   sysio_decode #(.IO_AW(IO_AW)) u_decode (
      .addr (io_addr),
      .sel  (sel)
   );

   sysio_ctrl_regs #(.MAP_RESET(MAP_RESET)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (io_wr),
      .wdata    (io_wdata),
      .sel      (sel),
      .sreset_q (sreset_q),
      .sysctl_q (sysctl_q),
      .map_q    (map_q),
      .le_err_q (le_err_q)
   );

   if (STRAPS_FROM_PINS) begin : g_strap_pins
      assign equip_v = equip_strap;
      assign board_v = board_strap;
   end else begin : g_strap_fixed
      logic unused_straps;
      assign unused_straps = ^{equip_strap, board_strap};
      assign equip_v = EQUIP_FIXED;
      assign board_v = BOARD_FIXED;
   end

   sysio_rdmux #(.UNMAPPED(UNMAPPED_READ)) u_rdmux (
      .sel      (sel),
      .sreset_q (sreset_q),
      .sysctl_q (sysctl_q),
      .map_q    (map_q),
      .equip    (equip_v),
      .board    (board_v),
      .rdata    (io_rdata)
   );

   sysio_parity_win #(
      .MM_AW     (MM_AW),
      .MM_DW     (MM_DW),
      .WIN_BYTES (WIN_BYTES),
      .BASE      (PARITY_BASE)
   ) u_parity (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (mm_addr),
      .rd    (mm_rd),
      .wr    (mm_wr),
      .size  (mm_size),
      .rdata (mm_rdata),
      .ack   (mm_ack),
      .bad_q (mm_bad_o)
   );

   assign soft_reset_o    = |(sreset_q & SR_BIT);
   assign map_noncontig_o = |(map_q & MAP_BIT);
   assign le_error_o      = le_err_q;

endmodule

// File: rtl/sysio_regs_chk.sv
module sysio_regs_chk #(
   parameter int          IO_AW       = 16,
   parameter int          MM_AW       = 32,
   parameter logic [31:0] PARITY_BASE = 32'hBFFF_EFF0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IO_AW-1:0] io_addr,
   input logic             io_wr,
   input logic [7:0]       io_wdata,
   input logic [7:0]       io_rdata,
   input logic             soft_reset_o,
   input logic             map_noncontig_o,
   input logic             le_error_o,
   input logic [MM_AW-1:0] mm_addr,
   input logic             mm_rd,
   input logic             mm_wr,
   input logic [1:0]       mm_size,
   input logic             mm_ack,
   input logic             mm_bad_o
);

   logic unused_wd;
   assign unused_wd = ^io_wdata[7:2];

   logic wr_sr, wr_map, at_key, in_win;
   assign wr_sr  = io_wr && (io_addr == IO_AW'('h092));
   assign wr_map = io_wr && (io_addr == IO_AW'('h850));
   assign at_key = (io_addr == IO_AW'('h818));
   assign in_win = (mm_addr >= MM_AW'(PARITY_BASE)) && (mm_addr <= MM_AW'(PARITY_BASE + 32'd3));

   // R1
   a_r1_sreset_track: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sr |=> soft_reset_o == $past(io_wdata[0]));
   a_r1_sreset_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sr |=> $stable(soft_reset_o));
   // R2
   a_r2_le_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sr && io_wdata[1]) |=> le_error_o);
   a_r2_le_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      le_error_o |=> le_error_o);
   // R4
   a_r4_map_track: assert property (@(posedge clk) disable iff (!rst_n)
      wr_map |=> map_noncontig_o == $past(io_wdata[0]));
   a_r4_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_map |=> $stable(map_noncontig_o));
   // R7
   a_r7_keylock_zero: assert property (@(posedge clk) disable iff (!rst_n)
      at_key |-> io_rdata == 8'h00);
   // R10
   a_r10_ack_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mm_ack |-> (in_win && mm_rd && mm_size == 2'd2));
   // R11
   a_r11_bad_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && mm_wr) |=> mm_bad_o);
   a_r11_no_bad_outside: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_win && (mm_rd || mm_wr)) |=> !mm_bad_o);

endmodule

bind sysio_regs sysio_regs_chk #(
   .IO_AW       (IO_AW),
   .MM_AW       (MM_AW),
   .PARITY_BASE (PARITY_BASE)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .io_addr         (io_addr),
   .io_wr           (io_wr),
   .io_wdata        (io_wdata),
   .io_rdata        (io_rdata),
   .soft_reset_o    (soft_reset_o),
   .map_noncontig_o (map_noncontig_o),
   .le_error_o      (le_error_o),
   .mm_addr         (mm_addr),
   .mm_rd           (mm_rd),
   .mm_wr           (mm_wr),
   .mm_size         (mm_size),
   .mm_ack          (mm_ack),
   .mm_bad_o        (mm_bad_o)
);

// File: tb/sysio_regs_tb.sv
`timescale 1ns/1ps
module sysio_regs_tb;

   localparam logic [31:0] BASE = 32'hBFFF_EFF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [7:0]  equip_strap = 8'h4B;
   logic [7:0]  board_strap = 8'hA5;
   logic        soft_reset_o, map_noncontig_o, le_error_o;
   logic [31:0] mm_addr = '0;
   logic        mm_rd = 1'b0, mm_wr = 1'b0;
   logic [1:0]  mm_size = 2'd0;
   logic [31:0] mm_rdata;
   logic        mm_ack, mm_bad_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sysio_regs u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .equip_strap(equip_strap), .board_strap(board_strap),
      .soft_reset_o(soft_reset_o), .map_noncontig_o(map_noncontig_o), .le_error_o(le_error_o),
      .mm_addr(mm_addr), .mm_rd(mm_rd), .mm_wr(mm_wr), .mm_size(mm_size),
      .mm_rdata(mm_rdata), .mm_ack(mm_ack), .mm_bad_o(mm_bad_o)
   );

   // behavioural reference model
   int m_sr, m_sc, m_map, m_le, m_bad;

   function automatic bit win(input logic [31:0] a);
      return (a >= BASE) && (a <= BASE + 32'd3);
   endfunction

   function automatic int m_read(input logic [15:0] a);
      case (a)
         16'h092: return m_sr;
         16'h81C: return m_sc;
         16'h850: return m_map;
         16'h80C: return int'(equip_strap);
         16'h852: return int'(board_strap);
         16'h818: return 0;
         default: return 'hFF;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sr = 0; m_sc = 0; m_map = 1; m_le = 0; m_bad = 0;
      end else begin
         if (io_wr) begin
            if (io_addr == 16'h092) begin
               m_sr = int'(io_wdata) % 2;
               if ((int'(io_wdata) / 2) % 2 == 1) m_le = 1;
            end else if (io_addr == 16'h81C) begin
               m_sc = (int'(io_wdata) / 16) * 16;
            end else if (io_addr == 16'h850) begin
               m_map = int'(io_wdata) % 2;
            end
         end
         m_bad = (win(mm_addr) && (mm_wr || (mm_rd && mm_size != 2'd2))) ? 1 : 0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 soft_reset_o", soft_reset_o, m_sr);
         chk("R4 map_noncontig_o", map_noncontig_o, m_map);
         chk("R2 le_error_o", le_error_o, m_le);
         chk("R11 mm_bad_o", mm_bad_o, m_bad);
         chk("R9 io_rdata model", io_rdata, m_read(io_addr));
         chk("R10 mm_ack model", mm_ack, (win(mm_addr) && mm_rd && mm_size == 2'd2) ? 1 : 0);
      end
   end

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(posedge clk); #2;
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(posedge clk); #2;
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] a, input logic [7:0] exp, input string req);
      @(posedge clk); #2;
      io_addr = a;
      @(negedge clk);
      chk(req, io_rdata, exp);
   endtask

   task automatic mm_access(input logic [31:0] a, input bit r, input bit w, input logic [1:0] sz,
                            input bit exp_ack, input bit exp_bad, input string req);
      @(posedge clk); #2;
      mm_addr = a; mm_rd = r; mm_wr = w; mm_size = sz;
      @(negedge clk);
      chk(req, mm_ack, exp_ack);
      if (exp_ack) chk("R10 mm_rdata", mm_rdata, 32'h0);
      @(posedge clk); #2;
      mm_rd = 1'b0; mm_wr = 1'b0;
      @(negedge clk);
      chk(req, mm_bad_o, exp_bad);
   endtask

   task automatic do_reset();
      @(posedge clk); #2;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R5 reset map", map_noncontig_o, 1'b1);
      chk("R5 reset sreset", soft_reset_o, 1'b0);
      chk("R5 reset le", le_error_o, 1'b0);
      chk("R5 reset bad", mm_bad_o, 1'b0);
      @(posedge clk); #2;
      rst_n = 1'b1;
   endtask

   task automatic outs_unchanged(input bit sr, input bit map, input bit le, input string req);
      @(negedge clk);
      chk(req, soft_reset_o, sr);
      chk(req, map_noncontig_o, map);
      chk(req, le_error_o, le);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      do_reset();
      // R5 reset state
      io_read(16'h092, 8'h00, "R5 port 092 after reset");
      io_read(16'h81C, 8'h00, "R5 port 81C after reset");
      io_read(16'h850, 8'h01, "R5 port 850 after reset");
      // R6 straps, R7 keylock, R8 sinks, R9 undecoded
      io_read(16'h80C, 8'h4B, "R6 equipment strap");
      io_read(16'h852, 8'hA5, "R6 board strap");
      io_read(16'h818, 8'h00, "R7 keylock");
      io_read(16'h808, 8'hFF, "R8 sink read");
      io_read(16'h814, 8'hFF, "R8 sink read");
      io_read(16'h123, 8'hFF, "R9 undecoded read");
      // R1 soft reset
      io_write(16'h092, 8'h01);
      io_read(16'h092, 8'h01, "R1 store 01");
      chk("R1 soft_reset_o high", soft_reset_o, 1'b1);
      io_write(16'h092, 8'h00);
      io_read(16'h092, 8'h00, "R1 store 00");
      io_write(16'h092, 8'hFD);
      io_read(16'h092, 8'h01, "R1 mask FD");
      chk("R2 no LE for FD", le_error_o, 1'b0);
      // R3 system control
      io_write(16'h81C, 8'hFF);
      io_read(16'h81C, 8'hF0, "R3 mask FF");
      io_write(16'h81C, 8'h5A);
      io_read(16'h81C, 8'h50, "R3 mask 5A");
      io_write(16'h81C, 8'h0F);
      io_read(16'h81C, 8'h00, "R3 mask 0F");
      io_write(16'h81C, 8'hA0);
      // R4 map mode
      io_write(16'h850, 8'h00);
      io_read(16'h850, 8'h00, "R4 store 00");
      chk("R4 map low", map_noncontig_o, 1'b0);
      io_write(16'h850, 8'hFE);
      io_read(16'h850, 8'h00, "R4 mask FE");
      io_write(16'h850, 8'h01);
      io_read(16'h850, 8'h01, "R4 store 01");
      // R8 sink writes, R6/R7 read-only writes, R9 undecoded writes
      io_write(16'h808, 8'h00);
      io_write(16'h810, 8'hFF);
      io_write(16'h812, 8'h00);
      io_write(16'h814, 8'h00);
      io_write(16'h80C, 8'h00);
      io_write(16'h852, 8'h00);
      io_write(16'h818, 8'hFF);
      io_write(16'h400, 8'h00);
      io_write(16'h093, 8'h02);
      outs_unchanged(1'b1, 1'b1, 1'b0, "R8 outputs after ignored writes");
      io_read(16'h092, 8'h01, "R8 sreset kept");
      io_read(16'h81C, 8'hA0, "R8 sysctl kept");
      io_read(16'h850, 8'h01, "R8 map kept");
      io_read(16'h80C, 8'h4B, "R6 strap unchanged by write");
      io_read(16'h818, 8'h00, "R7 keylock after write");
      // R6 straps follow pins
      equip_strap = 8'h3C; board_strap = 8'h81;
      io_read(16'h80C, 8'h3C, "R6 equipment follows pin");
      io_read(16'h852, 8'h81, "R6 board follows pin");
      // R10 / R11 parity window
      mm_access(BASE,          1, 0, 2'd2, 1, 0, "R10 word read base");
      mm_access(BASE + 32'd3,  1, 0, 2'd2, 1, 0, "R10 word read top");
      mm_access(BASE,          1, 0, 2'd0, 0, 1, "R11 byte read");
      mm_access(BASE + 32'd2,  1, 0, 2'd1, 0, 1, "R11 half read");
      mm_access(BASE,          0, 1, 2'd2, 0, 1, "R11 word write");
      mm_access(BASE + 32'd4,  1, 0, 2'd2, 0, 0, "R10 outside above");
      mm_access(BASE - 32'd1,  0, 1, 2'd0, 0, 0, "R11 outside below");
      // R2 little-endian request
      io_write(16'h092, 8'h02);
      @(negedge clk);
      chk("R2 le set", le_error_o, 1'b1);
      chk("R2 sreset cleared", soft_reset_o, 1'b0);
      io_write(16'h092, 8'h00);
      io_write(16'h092, 8'h01);
      @(negedge clk);
      chk("R2 le sticky", le_error_o, 1'b1);
      // R5 reset mid-run restores everything
      do_reset();
      io_read(16'h092, 8'h00, "R5 092 after second reset");
      io_read(16'h81C, 8'h00, "R5 81C after second reset");
      io_read(16'h850, 8'h01, "R5 850 after second reset");
      chk("R5 le cleared", le_error_o, 1'b0);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule